// File: doc/BRIEF.md
# ARINC 429 Buffered Word Transmitter

This block queues 32-bit ARINC 429 words written by a host and sends them one after another as a return-to-zero signal on a pair of logic-level lines, `lineHi` and `lineLo`, which feed an external line driver. A single-cycle reference tick input sets the timing. Each bit cell lasts 10 ticks at high speed and 80 ticks at low speed, and the per-word speed bit picks between the two. The transmitter computes the parity bit itself. That bit is normally odd and can be forced even, so that a receiver's parity checker can be tested over a loopback path.

The host loads words through a plain write strobe. It can hold `holdTx` high to fill a burst first and start sending only when it releases the hold. After each word the transmitter leaves the lines idle for a fixed gap. A status output shows when the queue is empty. A sticky flag records any write that arrived while the queue was full.

Top module: `a429_word_tx`

## Requirements
- R1: After reset both lines are low (null), `fifoEmpty` is 1 and `overflow` is 0.
- R2: While `holdTx` is 1 no new word starts, both lines stay null once any word in flight has finished, and queued words stay queued (`fifoEmpty` stays 0).
- R3: Words are sent in the order they were written. `fifoEmpty` is 1 exactly when no word is stored. Once the queue drains it returns to 1.
- R4: For a 1 bit, `lineHi` is high for the first half of the bit cell. For a 0 bit, `lineLo` is high for the first half. Both lines are low during the second half, and the two lines are never high together.
- R5: A bit cell lasts 10 reference ticks when `lowSpeed` is 0 and 80 ticks when it is 1. The speed is taken at the start of each word.
- R6: The first bit sent is `wrData[7]`, followed by the rest of the label byte down to `wrData[0]`. Next come `wrData[8]` through `wrData[30]` in ascending order. The parity bit is sent last.
- R7: The parity bit is computed from `wrData[30:0]`, and `wrData[31]` is ignored. When `evenParity` is 0, the 32 bits sent contain an odd number of ones. When it is 1, they contain an even number. The setting is taken when the word is loaded.
- R8: After the last bit cell of a word the lines stay null for at least 4 bit times. When the next word is already queued and `holdTx` is 0, the gap is exactly 4 bit times.
- R9: The queue holds 32 words. A write while 32 words are stored is dropped and sets `overflow`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | One-cycle rate reference tick (10x or 80x the bit rate) |
| lowSpeed | input | 1 | 1 selects 80 ticks per bit, 0 selects 10 |
| evenParity | input | 1 | 1 forces even parity instead of odd |
| holdTx | input | 1 | 1 prevents new words from starting |
| wrEn | input | 1 | Write strobe for the queue |
| wrData | input | 32 | Word to queue; bit 31 is ignored |
| fifoEmpty | output | 1 | 1 when the queue holds no word |
| overflow | output | 1 | Sticky flag for a write dropped while full |
| lineHi | output | 1 | High-side line level |
| lineLo | output | 1 | Low-side line level |

## Verification
On every cycle the assertions check the queue bookkeeping, the control sequencing and the tick gating. They check that a word is never loaded from an empty queue, that a full-queue write changes nothing except raising the sticky flag, that the flag never falls, that a held idle state never starts a word, that the gap always follows the final bit, and that the counters freeze between ticks. Some behaviour is only visible across a whole word on the lines: bit order, parity value, half-cell pulse widths, exact gap length and word order. The bench shows these by decoding the line pair back into words and measuring each null and pulse run.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // pop queue head into the shifter
    logic shift;  // advance to the next bit
    logic drive;  // first half of a bit cell: put the bit on the lines
  } txStrobe_t;

endpackage

// File: rtl/a429_tx_path.sv
module a429_tx_path
  import a429_tx_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int WORD_W = 32,
  parameter int LBL_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              evenParity,
  input  txStrobe_t         strb,
  output logic              fifoEmpty,
  output logic              overflow,
  output logic              lineHi,
  output logic              lineLo
);

  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int DAT_W = WORD_W - 1;  // top bit is regenerated as parity

  logic [DAT_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             isFull, wrOk;
  logic [DAT_W-1:0] headWord;
  logic [WORD_W-1:0] ordered;
  logic [WORD_W-1:0] shReg;
  logic             unusedMsb;

  assign unusedMsb = wrData[WORD_W-1];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign isFull    = (count == CNT_W'(DEPTH));
  assign fifoEmpty = (count == '0);
  assign wrOk      = wrEn && !isFull;
  assign headWord  = mem[rdPtr];

  // Storage array
  always_ff @(posedge clk) begin
    if (wrOk) mem[wrPtr] <= wrData[DAT_W-1:0];
  end

  // Pointers, occupancy and sticky overflow
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (wrOk)      wrPtr <= nextPtr(wrPtr);
      if (strb.load) rdPtr <= nextPtr(rdPtr);
      case ({wrOk, strb.load})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
      if (wrEn && isFull) overflow <= 1'b1;
    end
  end

  // Reorder into transmit order: label MSB first, then ascending, parity last
  always_comb begin
    ordered = '0;
    for (int i = 0; i < LBL_W; i++) ordered[i] = headWord[LBL_W-1-i];
    for (int i = LBL_W; i < DAT_W; i++) ordered[i] = headWord[i];
    ordered[WORD_W-1] = evenParity ? (^headWord) : ~(^headWord);
  end

  always_ff @(posedge clk) begin
    if (!rstN)           shReg <= '0;
    else if (strb.load)  shReg <= ordered;
    else if (strb.shift) shReg <= {1'b0, shReg[WORD_W-1:1]};
  end

  assign lineHi = strb.drive &  shReg[0];
  assign lineLo = strb.drive & ~shReg[0];

  // R3: the sequencer never loads from an empty queue
  a_r3_pop_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> !fifoEmpty);

  // R3: occupancy never exceeds the depth
  a_r3_count_range: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R9: flag is sticky
  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R9: a write while full is dropped and flagged
  a_r9_full_write_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && isFull && !strb.load) |=> (isFull && overflow));

endmodule

// File: rtl/a429_tx_ctrl.sv
module a429_tx_ctrl
  import a429_tx_pkg::*;
#(
  parameter int HI_DIV   = 10,
  parameter int LO_DIV   = 80,
  parameter int WORD_W   = 32,
  parameter int GAP_BITS = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      refTick,
  input  logic      lowSpeed,
  input  logic      holdTx,
  input  logic      fifoEmpty,
  output txStrobe_t strb
);

  localparam int MAX_DIV = (LO_DIV > HI_DIV) ? LO_DIV : HI_DIV;
  localparam int TW      = $clog2(MAX_DIV);
  localparam int MAX_BIT = (WORD_W > GAP_BITS) ? WORD_W : GAP_BITS;
  localparam int BW      = $clog2(MAX_BIT);

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_GAP} txState_t;

  txState_t      state;
  logic [TW-1:0] tickCnt;
  logic [BW-1:0] bitCnt;
  logic          lowLatch;
  logic [TW-1:0] divLast, halfVal;
  logic          startOk, cellEnd;

  assign divLast = lowLatch ? TW'(LO_DIV - 1) : TW'(HI_DIV - 1);
  assign halfVal = lowLatch ? TW'(LO_DIV / 2) : TW'(HI_DIV / 2);
  assign startOk = !fifoEmpty && !holdTx;
  assign cellEnd = refTick && (tickCnt == divLast);

  always_comb begin
    strb       = '0;
    strb.drive = (state == ST_SEND) && (tickCnt < halfVal);
    case (state)
      ST_IDLE: strb.load  = startOk;
      ST_SEND: strb.shift = cellEnd && (bitCnt != BW'(WORD_W - 1));
      ST_GAP:  strb.load  = cellEnd && (bitCnt == BW'(GAP_BITS - 1)) && startOk;
      default: strb       = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tickCnt  <= '0;
      bitCnt   <= '0;
      lowLatch <= 1'b0;
    end else if (strb.load) begin
      state    <= ST_SEND;
      tickCnt  <= '0;
      bitCnt   <= '0;
      lowLatch <= lowSpeed;
    end else if (state != ST_IDLE && refTick) begin
      if (tickCnt == divLast) begin
        tickCnt <= '0;
        if (state == ST_SEND) begin
          if (bitCnt == BW'(WORD_W - 1)) begin
            state  <= ST_GAP;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + BW'(1);
          end
        end else begin
          if (bitCnt == BW'(GAP_BITS - 1)) begin
            state  <= ST_IDLE;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + BW'(1);
          end
        end
      end else begin
        tickCnt <= tickCnt + TW'(1);
      end
    end
  end

  // R2: a held idle sequencer stays idle
  a_r2_hold_blocks_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && holdTx) |=> (state == ST_IDLE));

  // R8: the final bit cell is always followed by the gap
  a_r8_gap_follows_word: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND && cellEnd && bitCnt == BW'(WORD_W - 1)) |=> (state == ST_GAP));

  // R5: timing only advances on reference ticks
  a_r5_tick_gated: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && !refTick && !strb.load) |=> $stable(tickCnt));

endmodule

// File: rtl/a429_word_tx.sv
module a429_word_tx
  import a429_tx_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int WORD_W   = 32,
  parameter int HI_DIV   = 10,
  parameter int LO_DIV   = 80,
  parameter int GAP_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic              lowSpeed,
  input  logic              evenParity,
  input  logic              holdTx,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  output logic              fifoEmpty,
  output logic              overflow,
  output logic              lineHi,
  output logic              lineLo
);

  txStrobe_t strb;

  a429_tx_ctrl #(
    .HI_DIV(HI_DIV), .LO_DIV(LO_DIV), .WORD_W(WORD_W), .GAP_BITS(GAP_BITS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .refTick(refTick), .lowSpeed(lowSpeed),
    .holdTx(holdTx), .fifoEmpty(fifoEmpty), .strb(strb)
  );

  a429_tx_path #(
    .DEPTH(DEPTH), .WORD_W(WORD_W), .LBL_W(8)
  ) uPath (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .evenParity(evenParity), .strb(strb), .fifoEmpty(fifoEmpty),
    .overflow(overflow), .lineHi(lineHi), .lineLo(lineLo)
  );

  // R4: the two lines are never high together
  a_r4_lines_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(lineHi && lineLo));

endmodule

// File: tb/tb_a429_word_tx.sv
module tb_a429_word_tx;

  localparam int CLK_PERIOD = 10;
  localparam int HI_HALF = 5;
  localparam int LO_HALF = 40;

  typedef struct packed {
    logic [31:0] w;
    logic        ev;
    logic        lo;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{w: 32'h6000_00A5, ev: 1'b0, lo: 1'b0},
    '{w: 32'hFFFF_FFFF, ev: 1'b0, lo: 1'b0},
    '{w: 32'h0000_0000, ev: 1'b1, lo: 1'b0},
    '{w: 32'h7FFF_FF01, ev: 1'b1, lo: 1'b0},
    '{w: 32'h8000_0003, ev: 1'b0, lo: 1'b0},
    '{w: 32'h0000_0003, ev: 1'b0, lo: 1'b1},
    '{w: 32'h1234_5680, ev: 1'b1, lo: 1'b1}
  };

  logic clk = 0, rstN = 0, refTick = 1, lowSpeed = 0, evenParity = 0;
  logic holdTx = 1, wrEn = 0;
  logic [31:0] wrData = '0;
  logic fifoEmpty, overflow, lineHi, lineLo;

  int checks = 0, fails = 0;

  a429_word_tx dut (
    .clk(clk), .rstN(rstN), .refTick(refTick), .lowSpeed(lowSpeed),
    .evenParity(evenParity), .holdTx(holdTx), .wrEn(wrEn), .wrData(wrData),
    .fifoEmpty(fifoEmpty), .overflow(overflow), .lineHi(lineHi), .lineLo(lineLo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Line decoder
  int nullRun = 1000, hiRun = 0, bitIdx = 0, rxCount = 0;
  int pulseErr = 0, bothErr = 0, activeCyc = 0, curGap = 0, halfNow = HI_HALF;
  logic prevAct = 0, curVal = 0, act;
  logic [31:0] sBits, asm;
  logic [31:0] rxWord [64];
  int rxGap [64];

  always @(negedge clk) begin
    if (!rstN) begin
      nullRun = 1000; hiRun = 0; bitIdx = 0; prevAct = 0;
    end else begin
      act = lineHi | lineLo;
      if (lineHi && lineLo) bothErr++;
      if (act) begin
        activeCyc++;
        if (!prevAct) begin
          if (bitIdx == 0) curGap = nullRun;
          else if (nullRun != halfNow) pulseErr++;
          curVal = lineHi;
          hiRun = 1;
        end else begin
          hiRun++;
          if (lineHi != curVal) pulseErr++;
        end
      end else begin
        if (prevAct) begin
          if (hiRun != halfNow) pulseErr++;
          sBits[bitIdx] = curVal;
          bitIdx++;
          if (bitIdx == 32) begin
            for (int k = 0; k < 8; k++) asm[7-k] = sBits[k];
            for (int k = 8; k < 32; k++) asm[k] = sBits[k];
            rxWord[rxCount % 64] = asm;
            rxGap[rxCount % 64] = curGap;
            rxCount++;
            bitIdx = 0;
          end
          nullRun = 1;
        end else begin
          nullRun++;
        end
      end
      prevAct = act;
    end
  end

  function automatic logic [31:0] expWord(input logic [31:0] w, input logic ev);
    logic p;
    p = ev ? (^w[30:0]) : ~(^w[30:0]);
    return {p, w[30:0]};
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] actV, input logic [31:0] expV);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, actV, expV);
    end
  endtask

  task automatic writeWord(input logic [31:0] w);
    @(negedge clk);
    wrEn = 1; wrData = w;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic waitWords(input int n);
    int tgt;
    tgt = rxCount + n;
    while (rxCount < tgt) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int base, act0, pe0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(!lineHi && !lineLo, "R1", "lines null after reset", {30'd0, lineHi, lineLo}, 0);
    chk(fifoEmpty == 1, "R1", "empty after reset", fifoEmpty, 1);
    chk(overflow == 0, "R1", "no overflow after reset", overflow, 0);

    // Vector table: R6 order, R7 parity, R4/R5 pulse timing
    for (int v = 0; v < NVEC; v++) begin
      holdTx = 1;
      evenParity = VECS[v].ev;
      lowSpeed = VECS[v].lo;
      halfNow = VECS[v].lo ? LO_HALF : HI_HALF;
      pe0 = pulseErr;
      base = rxCount;
      writeWord(VECS[v].w);
      @(negedge clk);
      holdTx = 0;
      waitWords(1);
      chk(rxWord[base % 64] == expWord(VECS[v].w, VECS[v].ev), "R6/R7",
          "decoded word", rxWord[base % 64], expWord(VECS[v].w, VECS[v].ev));
      chk(($countones(rxWord[base % 64]) % 2) == (VECS[v].ev ? 0 : 1), "R7",
          "parity sense", $countones(rxWord[base % 64]), VECS[v].ev ? 0 : 1);
      chk(pulseErr == pe0, "R4/R5", "half-cell pulse and null widths",
          pulseErr - pe0, 0);
      repeat (VECS[v].lo ? 400 : 60) @(negedge clk);
    end
    // R7: bit 31 is ignored
    chk(rxWord[4] == rxWord[5], "R7", "bit 31 of entry ignored", rxWord[4], rxWord[5]);

    // R2 hold and R3/R8 burst
    evenParity = 0; lowSpeed = 0; halfNow = HI_HALF;
    holdTx = 1;
    writeWord(32'h0000_0111);
    writeWord(32'h0ABC_D222);
    writeWord(32'h4000_0333);
    base = rxCount;
    act0 = activeCyc;
    repeat (400) @(negedge clk);
    chk(rxCount == base, "R2", "no words during hold", rxCount - base, 0);
    chk(activeCyc == act0, "R2", "lines null during hold", activeCyc - act0, 0);
    chk(fifoEmpty == 0, "R2", "words kept while held", fifoEmpty, 0);
    pe0 = pulseErr;
    holdTx = 0;
    waitWords(3);
    chk(rxWord[base % 64] == expWord(32'h0000_0111, 0), "R3", "order word 0",
        rxWord[base % 64], expWord(32'h0000_0111, 0));
    chk(rxWord[(base+1) % 64] == expWord(32'h0ABC_D222, 0), "R3", "order word 1",
        rxWord[(base+1) % 64], expWord(32'h0ABC_D222, 0));
    chk(rxWord[(base+2) % 64] == expWord(32'h4000_0333, 0), "R3", "order word 2",
        rxWord[(base+2) % 64], expWord(32'h4000_0333, 0));
    chk(rxGap[(base+1) % 64] == HI_HALF + 40, "R8", "gap before word 1",
        rxGap[(base+1) % 64], HI_HALF + 40);
    chk(rxGap[(base+2) % 64] == HI_HALF + 40, "R8", "gap before word 2",
        rxGap[(base+2) % 64], HI_HALF + 40);
    chk(pulseErr == pe0, "R4", "burst pulse widths", pulseErr - pe0, 0);
    chk(bothErr == 0, "R4", "lines never both high", bothErr, 0);
    repeat (5) @(negedge clk);
    chk(fifoEmpty == 1, "R3", "empty after drain", fifoEmpty, 1);

    // R9 overflow
    repeat (60) @(negedge clk);
    holdTx = 1;
    for (int i = 0; i < 32; i++) writeWord(32'h0100_0000 + i);
    chk(overflow == 0, "R9", "no overflow at exactly 32", overflow, 0);
    chk(fifoEmpty == 0, "R3", "not empty when full", fifoEmpty, 0);
    writeWord(32'h5EAD_BEEF);
    chk(overflow == 1, "R9", "overflow on 33rd write", overflow, 1);
    base = rxCount;
    holdTx = 0;
    waitWords(32);
    chk(rxWord[base % 64] == expWord(32'h0100_0000, 0), "R9", "first stored word",
        rxWord[base % 64], expWord(32'h0100_0000, 0));
    chk(rxWord[(base+31) % 64] == expWord(32'h0100_001F, 0), "R9", "32nd stored word",
        rxWord[(base+31) % 64], expWord(32'h0100_001F, 0));
    repeat (600) @(negedge clk);
    chk(rxCount == base + 32, "R9", "dropped word never sent", rxCount - base, 32);
    chk(overflow == 1, "R9", "overflow stays set", overflow, 1);
    chk(fifoEmpty == 1, "R3", "empty after full drain", fifoEmpty, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule